// File: doc/BRIEF.md
# Host-Side Parallel Printer Port Controller

This block connects a host register bus to a parallel printer. It holds an 8-bit output data register, a control register whose bits drive the printer handshake lines, and a status register that samples the lines coming back from the printer. Each handshake output is active low and open drain. Here it is modelled as an enable: when the enable is 1, the pad pulls the line low.

The host reaches the three registers with a chip select, a 3-bit address and single-cycle read and write strobes. Read data is combinational while the read strobe is high, and the effects of a read or write take hold at the next clock edge. A rising edge on the acknowledge line latches a print flag. A mode pin chooses what drives the interrupt output: the acknowledge level itself, or that latched flag. A second pin chooses how the data port direction is set: the port always drives, or a direction bit in the control register decides.

Top module: `lpt_port`

## Requirements
- R1: After reset the control register is 0. All four handshake enables and `irq_oe` are 0, `pd_oe` is 1, the data register is 0 and the print flag is 0.
- R2: A write with `cs`=1 at address 0 loads the data register, which appears on `pd_out` after the next clock edge. A read of address 0 returns it while the port drives.
- R3: The control register sits at address 2 and its bits map to outputs as follows: bit 0 to `strobe_oe`, bit 1 to `autofeed_oe`, bit 2 to `init_oe`, bit 3 to `selin_oe`. A 1 asserts the line by enabling its low drive. A read returns the register in bits 5:0, with bits 7:6 read as 0.
- R4: The status register at address 1 reads as follows: bit 7 `busy`, bit 6 `ack_n`, bit 5 `paper_out`, bit 4 `selected`, bit 3 `fault_n`, bit 2 the print flag, and bits 1:0 zero. Each input level shows there one clock after it is applied.
- R5: When the sampled `ack_n` goes from 0 to 1, the print flag is set one clock later.
- R6: A status read returns the flag and clears it at that clock edge. If a rising acknowledge edge is detected in the same cycle, the flag stays set.
- R7: With `irq_mode`=0, `irq` equals the sampled `ack_n`. With `irq_mode`=1, `irq` equals the print flag.
- R8: `irq_oe` equals control bit 4.
- R9: With `enh_mode`=0, `pd_oe` is 1 whatever the value of control bit 5. With `enh_mode`=1, `pd_oe` is the inverse of control bit 5, where 1 means receive.
- R10: While `pd_oe`=0, a read of address 0 returns `pd_in` as sampled one clock earlier.
- R11: Writes to address 1 and to addresses 3 to 7 change nothing. Reads of addresses 3 to 7 return 0, and `rdata` is 0 when no read is selected.
- R12: A write with `cs`=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for the port registers |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| enh_mode | input | 1 | 0: data port always drives; 1: control bit 5 sets direction |
| irq_mode | input | 1 | 0: irq follows acknowledge; 1: irq is the latched print flag |
| pd_in | input | 8 | Data lines as seen at the pads |
| pd_out | output | 8 | Data register value to the pads |
| pd_oe | output | 1 | Data port drive enable |
| strobe_oe | output | 1 | Strobe low-drive enable |
| autofeed_oe | output | 1 | Autofeed low-drive enable |
| init_oe | output | 1 | Initialise low-drive enable |
| selin_oe | output | 1 | Select-in low-drive enable |
| busy | input | 1 | Printer not ready when high |
| paper_out | input | 1 | Printer out of paper when high |
| selected | input | 1 | Printer selected when high |
| fault_n | input | 1 | Printer error when low |
| ack_n | input | 1 | Acknowledge from printer, active low |
| irq | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The bench targets four corner cases.

- **Clear and set in the same cycle.** A status read coincides with a rising acknowledge edge. A design that gave the clear priority would lose that interrupt.
- **Direction pin with the direction bit set.** `enh_mode` is toggled while control bit 5 is 1. A design that ignored the pin would float the port in plain mode. A design that ignored the bit would drive against the printer.
- **Reads in receive mode.** Address 0 is read with the port receiving. It must return the pad sample and not the stale register.
- **Writes that must be ignored.** Writes go to the read-only status address, to unused addresses, and with chip select low. Each must leave all outputs unchanged. Otherwise a stray bus cycle would change the handshake lines.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int STAT_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_STAT = 3'd1,
        SEL_CTRL = 3'd2
    } reg_sel_e;

    // control register, packed MSB first: bit5 .. bit0
    typedef struct packed {
        logic dir_in;
        logic irq_en;
        logic sel_in;
        logic init;
        logic autofeed;
        logic strobe;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // status bit positions
    localparam int ST_FLAG  = 2;
    localparam int ST_FAULT = 3;
    localparam int ST_SEL   = 4;
    localparam int ST_PE    = 5;
    localparam int ST_ACK   = 6;
    localparam int ST_BUSY  = 7;
endpackage

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] data_q,
    output ctrl_t         ctrl_q,
    output logic          stat_rd
);
    typedef struct packed {
        logic [DW-1:0] data;
        ctrl_t         ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs && wr) begin
            case (addr)
                SEL_DATA: st_d.data = wdata;
                SEL_CTRL: st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q  = st_q.data;
    assign ctrl_q  = st_q.ctrl;
    assign stat_rd = cs && rd && (addr == SEL_STAT);
endmodule

// File: rtl/lpt_status_sampler.sv
module lpt_status_sampler
    import lpt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              paper_out,
    input  logic              selected,
    input  logic              fault_n,
    input  logic              ack_n,
    input  logic [DW-1:0]     pd_in,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] status,
    output logic              ack_lvl,
    output logic              flag,
    output logic [DW-1:0]     pd_smp
);
    typedef struct packed {
        logic          busy;
        logic          pe;
        logic          sel;
        logic          fault_n;
        logic          ack;
        logic          ack_prev;
        logic          flag;
        logic [DW-1:0] pd;
    } smp_t;

    smp_t st_d, st_q;
    logic ack_rise;

    always_comb begin
        st_d          = st_q;
        ack_rise      = st_q.ack && !st_q.ack_prev;
        st_d.busy     = busy;
        st_d.pe       = paper_out;
        st_d.sel      = selected;
        st_d.fault_n  = fault_n;
        st_d.ack      = ack_n;
        st_d.ack_prev = st_q.ack;
        st_d.pd       = pd_in;
        if (ack_rise)     st_d.flag = 1'b1;
        else if (stat_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.fault_n  <= 1'b1;
            st_q.ack      <= 1'b1;
            st_q.ack_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_BUSY]  = st_q.busy;
        status[ST_ACK]   = st_q.ack;
        status[ST_PE]    = st_q.pe;
        status[ST_SEL]   = st_q.sel;
        status[ST_FAULT] = st_q.fault_n;
        status[ST_FLAG]  = st_q.flag;
    end

    assign ack_lvl = st_q.ack;
    assign flag    = st_q.flag;
    assign pd_smp  = st_q.pd;
endmodule

// File: rtl/lpt_port.sv
module lpt_port
    import lpt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          enh_mode,
    input  logic          irq_mode,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          strobe_oe,
    output logic          autofeed_oe,
    output logic          init_oe,
    output logic          selin_oe,
    input  logic          busy,
    input  logic          paper_out,
    input  logic          selected,
    input  logic          fault_n,
    input  logic          ack_n,
    output logic          irq,
    output logic          irq_oe
);
    logic [DW-1:0]     data_q;
    ctrl_t             ctrl_q;
    logic              stat_rd;
    logic [STAT_W-1:0] status;
    logic              ack_lvl;
    logic              flag;
    logic [DW-1:0]     pd_smp;

    lpt_host_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .rd      (rd),
        .wr      (wr),
        .addr    (addr),
        .wdata   (wdata),
        .data_q  (data_q),
        .ctrl_q  (ctrl_q),
        .stat_rd (stat_rd)
    );

    lpt_status_sampler #(.DW(DW)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .paper_out (paper_out),
        .selected  (selected),
        .fault_n   (fault_n),
        .ack_n     (ack_n),
        .pd_in     (pd_in),
        .stat_rd   (stat_rd),
        .status    (status),
        .ack_lvl   (ack_lvl),
        .flag      (flag),
        .pd_smp    (pd_smp)
    );

    assign pd_oe       = !enh_mode || !ctrl_q.dir_in;
    assign pd_out      = data_q;
    assign strobe_oe   = ctrl_q.strobe;
    assign autofeed_oe = ctrl_q.autofeed;
    assign init_oe     = ctrl_q.init;
    assign selin_oe    = ctrl_q.sel_in;
    assign irq_oe      = ctrl_q.irq_en;
    assign irq         = irq_mode ? flag : ack_lvl;

    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            case (addr)
                SEL_DATA: rdata = pd_oe ? data_q : pd_smp;
                SEL_STAT: rdata = DW'(status);
                SEL_CTRL: rdata = DW'(ctrl_q);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       wr,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       enh_mode,
    input logic       irq_mode,
    input logic       ack_n,
    input logic       pd_oe,
    input logic       strobe_oe,
    input logic       autofeed_oe,
    input logic       init_oe,
    input logic       selin_oe,
    input logic       irq,
    input logic       irq_oe
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_PD_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode |-> pd_oe); // R9
    AST_STROBE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 3'd2) |=> strobe_oe == $past(wdata[0])); // R3
    AST_IRQ_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 3'd2) |=> irq_oe == $past(wdata[4])); // R8
    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !irq_mode) |-> irq == $past(ack_n)); // R7
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> $stable({strobe_oe, autofeed_oe, init_oe, selin_oe, irq_oe})); // R12
endmodule

bind lpt_port lpt_port_chk u_lpt_port_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .wr          (wr),
    .addr        (addr),
    .wdata       (wdata),
    .enh_mode    (enh_mode),
    .irq_mode    (irq_mode),
    .ack_n       (ack_n),
    .pd_oe       (pd_oe),
    .strobe_oe   (strobe_oe),
    .autofeed_oe (autofeed_oe),
    .init_oe     (init_oe),
    .selin_oe    (selin_oe),
    .irq         (irq),
    .irq_oe      (irq_oe)
);

// File: tb/lpt_port_bench.sv
module lpt_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, rd = 0, wr = 0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       enh_mode = 0, irq_mode = 0;
    logic [7:0] pd_in = '0;
    logic [7:0] pd_out;
    logic       pd_oe, strobe_oe, autofeed_oe, init_oe, selin_oe;
    logic       busy = 0, paper_out = 0, selected = 0, fault_n = 1, ack_n = 1;
    logic       irq, irq_oe;

    lpt_port u_lpt_port (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit [7:0] m_data;
    bit [5:0] m_ctrl;
    bit       m_busy, m_pe, m_sel, m_fn, m_ack, m_ackp, m_flag;
    bit [7:0] m_pd;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_oe();
        return !enh_mode || !m_ctrl[5];
    endfunction

    function automatic bit [7:0] exp_rdata();
        if (!(cs && rd)) return 8'h00;
        case (addr)
            3'd0: return exp_oe() ? m_data : m_pd;
            3'd1: return {m_busy, m_ack, m_pe, m_sel, m_fn, m_flag, 2'b00};
            3'd2: return {2'b00, m_ctrl};
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(string req);
        bit nf;
        #1;
        chk(req, "rdata", rdata, exp_rdata());
        chk(req, "pd_out", pd_out, m_data);
        chk(req, "pd_oe", {7'd0, pd_oe}, {7'd0, exp_oe()});
        chk(req, "ctrl_lines", {4'd0, selin_oe, init_oe, autofeed_oe, strobe_oe}, {4'd0, m_ctrl[3:0]});
        chk(req, "irq_oe", {7'd0, irq_oe}, {7'd0, m_ctrl[4]});
        chk(req, "irq", {7'd0, irq}, {7'd0, (irq_mode ? m_flag : m_ack)});
        @(posedge clk);
        nf = (m_ack && !m_ackp) ? 1'b1 : ((cs && rd && addr == 3'd1) ? 1'b0 : m_flag);
        m_flag = nf;
        m_ackp = m_ack;
        m_ack  = ack_n;
        m_busy = busy; m_pe = paper_out; m_sel = selected; m_fn = fault_n;
        m_pd   = pd_in;
        if (cs && wr && addr == 3'd0) m_data = wdata;
        if (cs && wr && addr == 3'd2) m_ctrl = wdata[5:0];
        @(negedge clk);
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d, string req, bit sel = 1);
        cs = sel; wr = 1; addr = a; wdata = d;
        step(req);
        cs = 0; wr = 0;
    endtask

    task automatic bus_rd(logic [2:0] a, string req);
        cs = 1; rd = 1; addr = a;
        step(req);
        cs = 0; rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_fn = 1; m_ack = 1; m_ackp = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step("R1");
        chk("R1", "pd_oe_direct", {7'd0, pd_oe}, 8'h01);
        bus_rd(3'd2, "R1");
        // R2 data write and read back
        bus_wr(3'd0, 8'hA5, "R2");
        bus_rd(3'd0, "R2");
        chk("R2", "pd_out_direct", pd_out, 8'hA5);
        // R3 control line mapping, one bit at a time
        for (int i = 0; i < 4; i++) begin
            bus_wr(3'd2, 8'h01 << i, "R3");
            bus_rd(3'd2, "R3");
        end
        bus_wr(3'd2, 8'hCF, "R3");
        bus_rd(3'd2, "R3");
        // R4 status inputs
        busy = 1; paper_out = 1; selected = 1; fault_n = 0;
        step("R4");
        bus_rd(3'd1, "R4");
        busy = 0; selected = 0;
        bus_rd(3'd1, "R4");
        // R5 acknowledge pulse sets flag
        ack_n = 0; step("R5"); step("R5");
        ack_n = 1; step("R5"); step("R5");
        bus_rd(3'd1, "R5");
        // R6 read clears; read coincides with edge keeps set
        bus_rd(3'd1, "R6");
        ack_n = 0; step("R6"); step("R6");
        ack_n = 1; step("R6");
        bus_rd(3'd1, "R6");
        bus_rd(3'd1, "R6");
        // R7 interrupt source modes
        irq_mode = 1;
        ack_n = 0; step("R7"); step("R7");
        ack_n = 1; step("R7"); step("R7"); step("R7");
        irq_mode = 0; step("R7");
        irq_mode = 1; bus_rd(3'd1, "R7"); step("R7");
        // R8 interrupt output enable
        bus_wr(3'd2, 8'h10, "R8");
        step("R8");
        bus_wr(3'd2, 8'h00, "R8");
        // R9 direction control
        bus_wr(3'd2, 8'h20, "R9");
        enh_mode = 0; step("R9");
        enh_mode = 1; step("R9");
        // R10 receive mode read
        pd_in = 8'h3C; step("R10");
        bus_rd(3'd0, "R10");
        pd_in = 8'hC3; bus_rd(3'd0, "R10");
        bus_rd(3'd0, "R10");
        bus_wr(3'd2, 8'h00, "R10");
        bus_rd(3'd0, "R10");
        // R11 ignored addresses
        bus_wr(3'd2, 8'h15, "R11");
        bus_wr(3'd1, 8'hFF, "R11");
        for (int a = 3; a < 8; a++) begin
            bus_wr(a[2:0], 8'hFF, "R11");
            bus_rd(a[2:0], "R11");
        end
        bus_rd(3'd2, "R11");
        bus_rd(3'd0, "R11");
        // R12 chip select low
        bus_wr(3'd2, 8'h0A, "R12", 1'b0);
        bus_wr(3'd0, 8'h11, "R12", 1'b0);
        bus_rd(3'd2, "R12");
        bus_rd(3'd0, "R12");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule